// File: doc/BRIEF.md
# Paired Command and Data Queues with Error Tracking

This block sits between a register bus and a serial-bus engine and holds two independent queues. The outbound queue stores 11-bit command words. Software writes them and the engine consumes them. The inbound queue stores bytes. The engine deposits them and software collects them. Each queue is 64 entries deep and has its own watermark, its own one-shot flush and its own pair of sticky misuse flags.

A single control word sets both watermarks and carries the two flush strobes. A status word reports the empty and full conditions and the four misuse flags. Three interrupt causes leave the block: outbound running low, inbound filling up, and any misuse. The engine side uses a plain valid/pop and ready/push handshake. Misuse from either side is recorded rather than blocked, so the flags also catch engine faults.

Top module: `dfifo_top`

## Requirements
- R1: After reset both queues are empty. `fifo_state` reads 0x008. `ctl_rdata` reads 0x1F0, which is inbound watermark 60 in bits 7:2 and outbound watermark 1 in bits 13:8. `irq_tx_aempty` is 1, and `irq_rx_afull` and `irq_fifo_err` are 0.
- R2: Words written with `txq_wr` appear on `eng_tx_cmd` in write order, all 11 bits intact. `eng_tx_valid` is high exactly when the outbound queue holds at least one word, and `fifo_state` bit 11 is high exactly when it holds 64.
- R3: Bytes pushed with `eng_rx_push` appear on `rxq_rdata` in push order during the cycle `rxq_rd` is high. `eng_rx_ready` is low exactly when 64 bytes are held, and `fifo_state` bit 3 is high exactly when none are held.
- R4: A `txq_wr` while the outbound queue is full is discarded and sets `fifo_state` bit 7. A pop in the same cycle still removes the head.
- R5: An `rxq_rd` while the inbound queue is empty returns 0 on `rxq_rdata`, leaves the queue unchanged and sets `fifo_state` bit 0.
- R6: An `eng_tx_pop` on an empty outbound queue sets `fifo_state` bit 6 and changes nothing else. An `eng_rx_push` on a full inbound queue discards the byte and sets `fifo_state` bit 1.
- R7: Each misuse flag stays set until its own queue is flushed. A flush of the other queue leaves it set.
- R8: `irq_fifo_err` is high exactly when any of `fifo_state` bits 0, 1, 6 or 7 is high.
- R9: A control write with bit 0 set empties the inbound queue and clears its flags at that clock edge. Bit 1 does the same for the outbound queue. A flush takes priority over a push or pop in the same cycle. Both strobe bits always read back as 0, and the watermark fields are taken from the same write.
- R10: `irq_tx_aempty` is high exactly when the outbound count is less than or equal to the watermark in control bits 13:8.
- R11: `irq_rx_afull` is high exactly when the inbound count is greater than or equal to the watermark in control bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 14 | Control word: flush strobes and watermarks |
| ctl_rdata | output | 14 | Control word readback, strobes read 0 |
| txq_wr | input | 1 | Bus write into the outbound queue |
| txq_wdata | input | 11 | Outbound command word |
| rxq_rd | input | 1 | Bus read from the inbound queue |
| rxq_rdata | output | 8 | Inbound head byte, 0 when empty |
| eng_tx_pop | input | 1 | Engine consumes the outbound head |
| eng_tx_cmd | output | 11 | Outbound head word |
| eng_tx_valid | output | 1 | Outbound queue not empty |
| eng_rx_push | input | 1 | Engine deposits a byte |
| eng_rx_byte | input | 8 | Byte from the engine |
| eng_rx_ready | output | 1 | Inbound queue not full |
| fifo_state | output | 12 | Status: flags, empty and full |
| irq_tx_aempty | output | 1 | Outbound at or below watermark |
| irq_rx_afull | output | 1 | Inbound at or above watermark |
| irq_fifo_err | output | 1 | Any misuse flag set |

## Verification
The bench drives a write into a full outbound queue in the same cycle as a pop. A design that tested the post-pop count would accept that word and leave bit 7 clear. It also drives a push into an empty queue in the same cycle as a read or pop. A design that checked emptiness after the push would deliver data instead of flagging the error. Flushes are issued alongside traffic and while the other queue holds errors, which exposes a flush that loses to a push or that clears the wrong flags. Watermarks are swept so that counts land exactly on them. An off-by-one compare therefore shows as a wrong interrupt in that single cycle.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  // status word bit positions (decoded by software)
  localparam int ST_W        = 12;
  localparam int ST_RX_RERR  = 0;
  localparam int ST_RX_WERR  = 1;
  localparam int ST_RX_EMPTY = 3;
  localparam int ST_TX_RERR  = 6;
  localparam int ST_TX_WERR  = 7;
  localparam int ST_TX_FULL  = 11;
  // control word bit positions
  localparam int CT_RX_FLUSH = 0;
  localparam int CT_TX_FLUSH = 1;
  localparam int CT_RX_THR   = 2;

  typedef enum logic {LVL_AT_OR_BELOW = 1'b0, LVL_AT_OR_ABOVE = 1'b1} lvl_mode_e;
endpackage

// File: rtl/dfifo_core.sv
module dfifo_core #(
  parameter int W     = 8,
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty,
  output logic                       full,
  output logic                       rerr,
  output logic                       werr
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rerr_q, rerr_d, werr_q, werr_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    rerr_d = rerr_q | (pop && empty);
    werr_d = werr_q | (push && full);
    if (push_ok) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (pop_ok)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
    if (flush) begin
      wp_d = '0; rp_d = '0; cnt_d = '0; rerr_d = 1'b0; werr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; rerr_q <= 1'b0; werr_q <= 1'b0;
    end else begin
      wp_q <= wp_d; rp_q <= rp_d; cnt_q <= cnt_d; rerr_q <= rerr_d; werr_q <= werr_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wp_q] <= push_data;
  end

  assign head_data = empty ? '0 : mem[rp_q];
  assign count     = cnt_q;
  assign rerr      = rerr_q;
  assign werr      = werr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full); // R4
  AST_EMPTY_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !flush) |=> rerr); // R5
  AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !flush) |=> werr); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rerr && !flush) |=> rerr); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && !rerr && !werr)); // R9
endmodule

// File: rtl/dfifo_level.sv
module dfifo_level
  import dfifo_pkg::*;
#(
  parameter int        CW   = 7,
  parameter int        TW   = 6,
  parameter lvl_mode_e MODE = LVL_AT_OR_BELOW
) (
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thr,
  output logic          hit
);
  logic [CW-1:0] thr_x;
  assign thr_x = CW'(thr);

  generate
    if (MODE == LVL_AT_OR_BELOW) begin : g_below
      assign hit = (count <= thr_x);
    end else begin : g_above
      assign hit = (count >= thr_x);
    end
  endgenerate
endmodule

// File: rtl/dfifo_top.sv
module dfifo_top
  import dfifo_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TX_W      = 11,
  parameter int RX_W      = 8,
  parameter int THR_W     = 6,
  parameter int RX_AF_DEF = 60,
  parameter int TX_AE_DEF = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctl_wr,
  input  logic [2+2*THR_W-1:0]   ctl_wdata,
  output logic [2+2*THR_W-1:0]   ctl_rdata,
  input  logic                   txq_wr,
  input  logic [TX_W-1:0]        txq_wdata,
  input  logic                   rxq_rd,
  output logic [RX_W-1:0]        rxq_rdata,
  input  logic                   eng_tx_pop,
  output logic [TX_W-1:0]        eng_tx_cmd,
  output logic                   eng_tx_valid,
  input  logic                   eng_rx_push,
  input  logic [RX_W-1:0]        eng_rx_byte,
  output logic                   eng_rx_ready,
  output logic [ST_W-1:0]        fifo_state,
  output logic                   irq_tx_aempty,
  output logic                   irq_rx_afull,
  output logic                   irq_fifo_err
);
  localparam int CW      = $clog2(DEPTH) + 1;
  localparam int CT_W    = 2 + 2*THR_W;
  localparam int TX_THR0 = CT_RX_THR + THR_W;

  logic [THR_W-1:0] rx_thr_q, rx_thr_d, tx_thr_q, tx_thr_d;
  logic             rx_flush, tx_flush;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_empty, tx_full, tx_rerr, tx_werr;
  logic             rx_empty, rx_full, rx_rerr, rx_werr;

  // flush strobes act at the write edge and are never stored
  assign rx_flush = ctl_wr && ctl_wdata[CT_RX_FLUSH];
  assign tx_flush = ctl_wr && ctl_wdata[CT_TX_FLUSH];

  always_comb begin
    rx_thr_d = rx_thr_q;
    tx_thr_d = tx_thr_q;
    if (ctl_wr) begin
      rx_thr_d = ctl_wdata[CT_RX_THR +: THR_W];
      tx_thr_d = ctl_wdata[TX_THR0 +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= THR_W'(RX_AF_DEF);
      tx_thr_q <= THR_W'(TX_AE_DEF);
    end else begin
      rx_thr_q <= rx_thr_d;
      tx_thr_q <= tx_thr_d;
    end
  end

  assign ctl_rdata = {tx_thr_q, rx_thr_q, 2'b00};

  dfifo_core #(.W(TX_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(txq_wr), .push_data(txq_wdata), .pop(eng_tx_pop),
    .head_data(eng_tx_cmd), .count(tx_cnt), .empty(tx_empty), .full(tx_full),
    .rerr(tx_rerr), .werr(tx_werr));

  dfifo_core #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(eng_rx_push), .push_data(eng_rx_byte), .pop(rxq_rd),
    .head_data(rxq_rdata), .count(rx_cnt), .empty(rx_empty), .full(rx_full),
    .rerr(rx_rerr), .werr(rx_werr));

  dfifo_level #(.CW(CW), .TW(THR_W), .MODE(LVL_AT_OR_BELOW)) u_tx_lvl (
    .count(tx_cnt), .thr(tx_thr_q), .hit(irq_tx_aempty));

  dfifo_level #(.CW(CW), .TW(THR_W), .MODE(LVL_AT_OR_ABOVE)) u_rx_lvl (
    .count(rx_cnt), .thr(rx_thr_q), .hit(irq_rx_afull));

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;

  always_comb begin
    fifo_state              = '0;
    fifo_state[ST_RX_RERR]  = rx_rerr;
    fifo_state[ST_RX_WERR]  = rx_werr;
    fifo_state[ST_RX_EMPTY] = rx_empty;
    fifo_state[ST_TX_RERR]  = tx_rerr;
    fifo_state[ST_TX_WERR]  = tx_werr;
    fifo_state[ST_TX_FULL]  = tx_full;
  end

  assign irq_fifo_err = rx_rerr | rx_werr | tx_rerr | tx_werr;

  AST_TX_EMPTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_tx_valid |-> irq_tx_aempty); // R10
  AST_RX_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_rx_ready |-> irq_rx_afull); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_state[ST_TX_WERR] || fifo_state[ST_RX_RERR]) |-> irq_fifo_err); // R8
  AST_STROBE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[1:0] == 2'b00); // R9
endmodule

// File: tb/sim_dfifo_top.sv
module sim_dfifo_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wr;
  logic [13:0] ctl_wdata, ctl_rdata;
  logic        txq_wr, rxq_rd, eng_tx_pop, eng_rx_push;
  logic [10:0] txq_wdata, eng_tx_cmd;
  logic [7:0]  rxq_rdata, eng_rx_byte;
  logic        eng_tx_valid, eng_rx_ready;
  logic [11:0] fifo_state;
  logic        irq_tx_aempty, irq_rx_afull, irq_fifo_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [10:0] mtx[$];
  logic [7:0]  mrx[$];
  int  m_rthr, m_tthr;
  bit  m_txr, m_txw, m_rxr, m_rxw;

  always #5 clk = ~clk;

  dfifo_top u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_state();
    int s = 0;
    if (m_rxr) s |= 1;
    if (m_rxw) s |= 2;
    if (mrx.size() == 0) s |= 8;
    if (m_txr) s |= 64;
    if (m_txw) s |= 128;
    if (mtx.size() == 64) s |= 2048;
    return s;
  endfunction

  task automatic check_all();
    int s = exp_state();
    chk("R2 tx full bit",   fifo_state[11], (s >> 11) & 1);
    chk("R2 tx valid",      eng_tx_valid, mtx.size() != 0);
    chk("R3 rx empty bit",  fifo_state[3], (s >> 3) & 1);
    chk("R3 rx ready",      eng_rx_ready, mrx.size() != 64);
    chk("R4 tx write err",  fifo_state[7], (s >> 7) & 1);
    chk("R5 rx read err",   fifo_state[0], s & 1);
    chk("R6 tx read err",   fifo_state[6], (s >> 6) & 1);
    chk("R6 rx write err",  fifo_state[1], (s >> 1) & 1);
    chk("R8 error irq",     irq_fifo_err, (s & 8'hC3) != 0);
    chk("R9 ctl readback",  ctl_rdata, (m_tthr << 8) | (m_rthr << 2));
    chk("R10 almost empty", irq_tx_aempty, mtx.size() <= m_tthr);
    chk("R11 almost full",  irq_rx_afull, mrx.size() >= m_rthr);
    chk("R1 unused state bits", fifo_state & 12'h734, 0);
  endtask

  // one clock: drive at negedge, combinational checks, model update, post-edge checks
  task automatic cyc(input bit twr, input logic [10:0] td, input bit rrd, input bit tpop,
                     input bit rpush, input logic [7:0] rb, input bit cwr, input logic [13:0] cd);
    int tsz = mtx.size();
    int rsz = mrx.size();
    txq_wr = twr; txq_wdata = td; rxq_rd = rrd; eng_tx_pop = tpop;
    eng_rx_push = rpush; eng_rx_byte = rb; ctl_wr = cwr; ctl_wdata = cd;
    #1;
    if (rrd) chk("R3 R5 read data", rxq_rdata, rsz ? mrx[0] : 0);
    if (tsz) chk("R2 tx head", eng_tx_cmd, mtx[0]);
    // model
    if (cwr && cd[1]) begin mtx.delete(); m_txr = 0; m_txw = 0; end
    else begin
      if (tpop) begin if (tsz == 0) m_txr = 1; else void'(mtx.pop_front()); end
      if (twr)  begin if (tsz == 64) m_txw = 1; else mtx.push_back(td); end
    end
    if (cwr && cd[0]) begin mrx.delete(); m_rxr = 0; m_rxw = 0; end
    else begin
      if (rrd)   begin if (rsz == 0) m_rxr = 1; else void'(mrx.pop_front()); end
      if (rpush) begin if (rsz == 64) m_rxw = 1; else mrx.push_back(rb); end
    end
    if (cwr) begin m_rthr = cd[7:2]; m_tthr = cd[13:8]; end
    @(negedge clk);
    txq_wr = 0; rxq_rd = 0; eng_tx_pop = 0; eng_rx_push = 0; ctl_wr = 0;
    #1;
    check_all();
  endtask

  function automatic logic [13:0] cfg(input int tthr, input int rthr, input bit ftx, input bit frx);
    return 14'((tthr << 8) | (rthr << 2) | (int'(ftx) << 1) | int'(frx));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24601));
    m_rthr = 60; m_tthr = 1;
    rst_n = 0; ctl_wr = 0; ctl_wdata = 0; txq_wr = 0; txq_wdata = 0; rxq_rd = 0;
    eng_tx_pop = 0; eng_rx_push = 0; eng_rx_byte = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset values
    chk("R1 state",      fifo_state, 12'h008);
    chk("R1 ctl",        ctl_rdata, 14'h1F0);
    chk("R1 irq aempty", irq_tx_aempty, 1);
    chk("R1 irq afull",  irq_rx_afull, 0);
    chk("R1 irq err",    irq_fifo_err, 0);

    // R5 read of empty inbound queue returns zero
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    chk("R5 flag set", fifo_state[0], 1);
    // R6 pop empty outbound queue
    cyc(0, 0, 0, 1, 0, 0, 0, 0);
    // fill outbound queue to 64 and overflow while popping (R4)
    for (int i = 0; i < 64; i++) cyc(1, 11'(i * 37 + 5), 0, 0, 0, 0, 0, 0);
    cyc(1, 11'h7FF, 0, 1, 0, 0, 0, 0);
    chk("R4 write dropped on full", fifo_state[7], 1);
    // R7 flushing inbound keeps outbound flags
    cyc(0, 0, 0, 0, 0, 0, 1, cfg(1, 60, 0, 1));
    chk("R7 tx flags kept", fifo_state[7:6], 2'b11);
    chk("R7 rx flags cleared", fifo_state[1:0], 2'b00);
    // drain outbound in order (R2)
    for (int i = 0; i < 63; i++) cyc(0, 0, 0, 1, 0, 0, 0, 0);
    // fill inbound to 64 plus one extra (R6), push with empty-read same cycle
    cyc(0, 0, 1, 0, 1, 8'hA5, 0, 0);
    for (int i = 0; i < 64; i++) cyc(0, 0, 0, 0, 1, 8'(i * 13 + 1), 0, 0);
    // flush outbound alongside traffic (R9)
    cyc(1, 11'h123, 0, 0, 0, 0, 1, cfg(3, 10, 1, 0));
    chk("R9 tx flushed", eng_tx_valid, 0);
    chk("R7 rx flags kept", fifo_state[1:0], 2'b11);
    // R10 boundary around watermark 3
    for (int i = 0; i < 5; i++) cyc(1, 11'(i), 0, 0, 0, 0, 0, 0);
    // drain inbound (R3, R11 boundary at 10)
    for (int i = 0; i < 64; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, cfg(1, 60, 1, 1));

    // random phases
    for (int ph = 0; ph < 30; ph++) begin
      int wbias = $urandom_range(0, 100);
      for (int k = 0; k < 150; k++) begin
        bit cw = ($urandom_range(0, 99) < 2);
        cyc($urandom_range(0, 99) < wbias, 11'($urandom), $urandom_range(0, 99) >= wbias,
            $urandom_range(0, 99) >= wbias, $urandom_range(0, 99) < wbias, 8'($urandom),
            cw, cfg($urandom_range(0, 63), $urandom_range(0, 63),
                    $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule